// File: doc/BRIEF.md
# SPI Controller with Mode-Fault Handling

This block moves 8-bit words over a four-wire serial link, either as the side that owns the serial clock or as the side that follows it. One control word selects the role, the enable, the interrupt enable, the clock idle level, the capture phase and, when it owns the clock, a clock divide. A data write loads the word to send and, in clock-owning mode, starts the exchange at once. The word shifted in lands in a read buffer when the eighth capture edge has passed, and a done flag is raised.

The select input serves two purposes. It frames transfers while the block follows. While the block owns the clock, a low level on it counts as a conflict. The block then raises a fault flag and clears both its enable and its role bit. This leaves it as a silent follower until software steps in. Each flag is cleared by reading the status and then making a specific access. An interrupt line reports either flag when interrupts are enabled.

Top module: `spi_ctrl`

## Requirements
- R1: In clock-owning mode (control bit 1 set, bit 0 set) a data write starts an exchange of 8 bits, most significant bit first. The bit sent on `mosi_out` and the bit taken from `miso_in` follow the selected mode, and the word received is readable on `data_rdata`. This holds for all four combinations of idle level and phase.
- R2: When no exchange runs, `sck_out` sits at the idle level in control bit 3. With control bit 4 clear, data is captured on the first edge of each bit and changed on the second. With bit 4 set, these two roles swap.
- R3: The serial clock period equals 4 << D system clocks, where D is control bits 6:5 (4, 8, 16 or 32).
- R4: In follower mode (bit 0 set, bit 1 clear), the block exchanges 8 bits, most significant bit first, using the synchronised `sck_in`, `mosi_in` and `ss_n_in`, in all four modes. It drives `miso_out` with `miso_oe` high only while `ss_n_in` is low.
- R5: In follower mode with phase 0, the first bit of the loaded word appears on `miso_out` after the select falls and before any clock edge.
- R6: A control write made while bit 0 is set leaves the stored idle level (bit 3) and the idle level of `sck_out` unchanged. While bit 0 is clear, such a write takes effect.
- R7: While the block is enabled in clock-owning mode, a low on `ss_n_in` sets `stat_fault` and clears control bits 0 and 1.
- R8: `irq` is high only when control bit 2 is set and at least one of `stat_done` and `stat_fault` is set. A fault with bit 2 clear leaves `irq` low.
- R9: `stat_fault` clears only on a control write that comes after a status read. A control write without a prior status read leaves it set.
- R10: `stat_done` rises on the eighth capture edge of an exchange. It clears only on a data read that comes after a status read.
- R11: While control bit 0 is clear, `sck_oe`, `mosi_oe` and `miso_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 7 | Control word: 0 enable, 1 clock owner, 2 irq enable, 3 idle level, 4 phase, 6:5 divide |
| ctrl_rdata | output | 7 | Current control word |
| stat_rd | input | 1 | Status read strobe (arms flag clearing) |
| stat_done | output | 1 | Exchange-complete flag |
| stat_fault | output | 1 | Mode-fault flag |
| data_wr | input | 1 | Data write strobe |
| data_wdata | input | 8 | Word to send |
| data_rd | input | 1 | Data read strobe |
| data_rdata | output | 8 | Last word received |
| irq | output | 1 | Interrupt request |
| sck_out | output | 1 | Serial clock out |
| sck_oe | output | 1 | Serial clock drive enable |
| sck_in | input | 1 | Serial clock in (follower) |
| mosi_out | output | 1 | Serial data out, owner side |
| mosi_oe | output | 1 | Owner data drive enable |
| mosi_in | input | 1 | Serial data in (follower) |
| miso_out | output | 1 | Serial data out, follower side |
| miso_oe | output | 1 | Follower data drive enable |
| miso_in | input | 1 | Serial data in (owner) |
| ss_n_in | input | 1 | Select input, active low |

## Verification
Clock-owning exchanges sweep every mode and every divide with two word pairs: a lopsided pair (A5/3C) and an edge pair (80/01). A bench-side follower model drives and samples on the edges it computes, so a capture on the wrong edge or a bit-order slip shows up as a data mismatch. The gap between leading edges separates the four divides. Follower exchanges run all four modes against a bench-side clock owner, and the phase-0 early bit is checked before the first edge. Separate sequences drive the select low with and without the interrupt enable. They attempt a flag clear without the prior status read, and they attempt an idle-level write while enabled and then while disabled.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  // Largest half period of the serial clock, in system clocks (divide 32).
  localparam int HALF_MAX = 16;

  typedef struct packed {
    logic [1:0] div;   // 6:5
    logic       pha;   // 4
    logic       pol;   // 3
    logic       ie;    // 2
    logic       mst;   // 1
    logic       en;    // 0
  } ctrl_t;

  // Half period of the serial clock for a divide select: (4 << sel) / 2.
  function automatic int unsigned half_ticks(input logic [1:0] sel);
    return 32'd2 << sel;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int DW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       tick,
  output logic       lead,
  output logic       last
);
  import spi_ctl_pkg::*;
  localparam int CNT_W = $clog2(HALF_MAX);
  localparam int EW    = $clog2(2 * DW);

  logic [CNT_W-1:0] cnt;
  logic [EW-1:0]    ecnt;

  assign tick = run && (cnt == CNT_W'(half_ticks(div_sel) - 1));
  assign lead = ~ecnt[0];
  assign last = (ecnt == EW'(2 * DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ecnt <= '0;
    end else if (!run) begin
      cnt  <= '0;
      ecnt <= '0;
    end else if (tick) begin
      cnt  <= '0;
      ecnt <= ecnt + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          pha,
  input  logic          edge_v,
  input  logic          lead,
  input  logic          din,
  output logic          dout,
  output logic          cap_evt,
  output logic          done_evt,
  output logic [DW-1:0] rx_word
);
  localparam int BW = $clog2(DW);

  logic [DW-1:0] sreg;
  logic [BW-1:0] bcnt;
  logic          out_q;
  logic          drv_evt;

  // Phase 0 captures on the leading edge, phase 1 on the trailing edge.
  assign cap_evt  = edge_v && (lead ^ pha);
  assign drv_evt  = edge_v && !(lead ^ pha);
  assign done_evt = cap_evt && (bcnt == BW'(DW - 1));
  assign rx_word  = {sreg[DW-2:0], din};
  assign dout     = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      bcnt  <= '0;
      out_q <= 1'b0;
    end else if (load) begin
      sreg  <= load_data;
      bcnt  <= '0;
      out_q <= load_data[DW-1];
    end else begin
      if (cap_evt) begin
        sreg <= rx_word;
        bcnt <= bcnt + 1'b1;
      end
      if (drv_evt) out_q <= sreg[DW-1];
    end
  end
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [6:0]    ctrl_wdata,
  output logic [6:0]    ctrl_rdata,
  input  logic          stat_rd,
  output logic          stat_done,
  output logic          stat_fault,
  input  logic          data_wr,
  input  logic [DW-1:0] data_wdata,
  input  logic          data_rd,
  output logic [DW-1:0] data_rdata,
  output logic          irq,
  output logic          sck_out,
  output logic          sck_oe,
  input  logic          sck_in,
  output logic          mosi_out,
  output logic          mosi_oe,
  input  logic          mosi_in,
  output logic          miso_out,
  output logic          miso_oe,
  input  logic          miso_in,
  input  logic          ss_n_in
);
  import spi_ctl_pkg::*;

  ctrl_t         ctrl_q, ctrl_nxt;
  logic          done_q, modf_q, armed_q;
  logic [DW-1:0] tx_buf, rx_buf;
  logic          m_busy, sck_q;
  logic          sck_s, mosi_s, ss_s, sck_s_d, ss_s_d;
  logic          m_tick, m_lead, m_last;
  logic          s_edge, s_lead, s_load, m_start;
  logic          fault_evt, cap_evt, done_evt, sh_dout;
  logic          sh_edge, sh_lead, sh_din, sh_load;
  logic [DW-1:0] sh_load_data, rx_word;
  logic          own_on, follow_on;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ss_n_in, sck_in, mosi_in}),
    .q({ss_s, sck_s, mosi_s})
  );

  assign own_on    = ctrl_q.en && ctrl_q.mst;
  assign follow_on = ctrl_q.en && !ctrl_q.mst;
  assign fault_evt = own_on && !ss_s;
  assign m_start   = data_wr && own_on && !m_busy && !fault_evt;
  assign s_edge    = follow_on && !ss_s && (sck_s != sck_s_d);
  assign s_lead    = (sck_s != ctrl_q.pol);
  assign s_load    = follow_on && ss_s_d && !ss_s;

  spi_sck_gen #(.DW(DW)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(m_busy), .div_sel(ctrl_q.div),
    .tick(m_tick), .lead(m_lead), .last(m_last)
  );

  assign sh_edge      = ctrl_q.mst ? m_tick  : s_edge;
  assign sh_lead      = ctrl_q.mst ? m_lead  : s_lead;
  assign sh_din       = ctrl_q.mst ? miso_in : mosi_s;
  assign sh_load      = m_start || s_load;
  assign sh_load_data = m_start ? data_wdata : tx_buf;

  spi_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_data(sh_load_data),
    .pha(ctrl_q.pha), .edge_v(sh_edge), .lead(sh_lead), .din(sh_din),
    .dout(sh_dout), .cap_evt(cap_evt), .done_evt(done_evt), .rx_word(rx_word)
  );

  // Control update: a fault demotes the block; idle level frozen while enabled.
  always_comb begin
    ctrl_nxt = ctrl_q;
    if (fault_evt) begin
      ctrl_nxt.en  = 1'b0;
      ctrl_nxt.mst = 1'b0;
    end else if (ctrl_wr) begin
      ctrl_nxt = ctrl_t'(ctrl_wdata);
      if (ctrl_q.en) ctrl_nxt.pol = ctrl_q.pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      modf_q  <= 1'b0;
      armed_q <= 1'b0;
      tx_buf  <= '0;
      rx_buf  <= '0;
      m_busy  <= 1'b0;
      sck_q   <= 1'b0;
      sck_s_d <= 1'b0;
      ss_s_d  <= 1'b1;
    end else begin
      ctrl_q  <= ctrl_nxt;
      sck_s_d <= sck_s;
      ss_s_d  <= ss_s;
      if (data_wr) tx_buf <= data_wdata;
      if (done_evt) rx_buf <= rx_word;

      if (fault_evt) modf_q <= 1'b1;
      else if (ctrl_wr && armed_q) modf_q <= 1'b0;

      if (done_evt) done_q <= 1'b1;
      else if (data_rd && armed_q) done_q <= 1'b0;

      if (stat_rd) armed_q <= 1'b1;
      else if (ctrl_wr || data_rd) armed_q <= 1'b0;

      if (m_start) m_busy <= 1'b1;
      else if (!own_on || fault_evt || (m_tick && m_last)) m_busy <= 1'b0;

      if (!m_busy) sck_q <= ctrl_q.pol;
      else if (m_tick) sck_q <= ~sck_q;
    end
  end

  assign ctrl_rdata = ctrl_q;
  assign stat_done  = done_q;
  assign stat_fault = modf_q;
  assign data_rdata = rx_buf;
  assign irq        = ctrl_q.ie && (done_q || modf_q);
  assign sck_out    = m_busy ? sck_q : ctrl_q.pol;
  assign sck_oe     = own_on;
  assign mosi_out   = sh_dout;
  assign mosi_oe    = own_on;
  assign miso_out   = sh_dout;
  assign miso_oe    = follow_on && !ss_s;
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] ctrl_rdata,
  input logic       stat_fault,
  input logic       stat_done,
  input logic       irq,
  input logic       sck_oe,
  input logic       mosi_oe,
  input logic       miso_oe,
  input logic       cap_evt
);
  AST_FAULT_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_fault) |-> (ctrl_rdata[1:0] == 2'b00)); // R7
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[2] |-> !irq); // R8
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[0] |-> !(sck_oe || mosi_oe || miso_oe)); // R11
  AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[0] && $past(ctrl_rdata[0])) |-> $stable(ctrl_rdata[3])); // R6
  AST_DONE_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_done) |-> $past(cap_evt)); // R10
  AST_ONE_DATA_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(mosi_oe && miso_oe)); // R4
endmodule

bind spi_ctrl spi_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_rdata(ctrl_rdata), .stat_fault(stat_fault),
  .stat_done(stat_done), .irq(irq), .sck_oe(sck_oe), .mosi_oe(mosi_oe),
  .miso_oe(miso_oe), .cap_evt(cap_evt)
);

// File: tb/tb_spi_ctrl.sv
module tb_spi_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_wr = 0, stat_rd = 0, data_wr = 0, data_rd = 0;
  logic [6:0] ctrl_wdata = '0, ctrl_rdata;
  logic [7:0] data_wdata = '0, data_rdata;
  logic stat_done, stat_fault, irq;
  logic sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;
  logic sck_in = 0, mosi_in = 0, miso_in = 0, ss_n_in = 1;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .stat_rd(stat_rd), .stat_done(stat_done),
    .stat_fault(stat_fault), .data_wr(data_wr), .data_wdata(data_wdata),
    .data_rd(data_rd), .data_rdata(data_rdata), .irq(irq), .sck_out(sck_out),
    .sck_oe(sck_oe), .sck_in(sck_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .mosi_in(mosi_in), .miso_out(miso_out), .miso_oe(miso_oe),
    .miso_in(miso_in), .ss_n_in(ss_n_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] cfg(input logic [1:0] dv, input logic ph, po, ie, ms, en);
    return {dv, ph, po, ie, ms, en};
  endfunction

  task automatic wr_ctrl(input logic [6:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 0;
  endtask
  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_wr = 1; data_wdata = v;
    @(negedge clk); data_wr = 0;
  endtask
  task automatic rd_stat();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask
  task automatic rd_data();
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
  endtask

  // Clock-owning exchange against a bench follower model.
  task automatic m_xfer(input logic [1:0] dv, input logic ph, po, input logic [7:0] mtx, stx);
    logic [7:0] got;
    logic prev, lead;
    int bp, edges, cyc, l1, l2;
    wr_ctrl(7'h00);
    wr_ctrl(cfg(dv, ph, po, 1'b0, 1'b1, 1'b1));
    miso_in = stx[7];
    bp = ph ? 7 : 6;
    got = '0; edges = 0; cyc = 0; l1 = -1; l2 = -1;
    chk("R2 idle level before start", sck_out, po);
    wr_data(mtx);
    prev = po;
    while (edges < 16 && cyc < 4000) begin
      @(negedge clk); cyc++;
      if (sck_out !== prev) begin
        prev = sck_out; edges++;
        lead = (sck_out != po);
        if (lead) begin
          if (l1 < 0) l1 = cyc; else if (l2 < 0) l2 = cyc;
        end
        if (lead ^ ph) got = {got[6:0], mosi_out};
        else begin
          if (bp >= 0) miso_in = stx[bp];
          bp--;
        end
      end
    end
    repeat (3) @(negedge clk);
    chk("R1 owner sent word", got, mtx);
    chk("R1 owner received word", data_rdata, stx);
    chk("R3 sck period", l2 - l1, 4 << dv);
    chk("R2 idle level after exchange", sck_out, po);
    chk("R10 done after eighth capture", stat_done, 1);
    rd_data();
    chk("R10 data read without status read keeps done", stat_done, 1);
    rd_stat(); rd_data();
    chk("R10 done cleared", stat_done, 0);
  endtask

  // Follower exchange against a bench clock-owner model.
  task automatic s_xfer(input logic ph, po, input logic [7:0] mtx, stx);
    logic [7:0] got;
    int bp;
    wr_ctrl(7'h00);
    sck_in = po; ss_n_in = 1; mosi_in = 0;
    wr_ctrl(cfg(2'd0, ph, po, 1'b0, 1'b0, 1'b1));
    wr_data(stx);
    repeat (4) @(negedge clk);
    chk("R4 miso idle while deselected", miso_oe, 0);
    ss_n_in = 0; mosi_in = mtx[7];
    bp = ph ? 7 : 6;
    got = '0;
    repeat (8) @(negedge clk);
    chk("R4 miso driven while selected", miso_oe, 1);
    if (!ph) chk("R5 first bit before any edge", miso_out, stx[7]);
    for (int e = 1; e <= 16; e++) begin
      if (((e % 2) == 1) ^ ph) begin
        got = {got[6:0], miso_out};
        sck_in = ~sck_in;
      end else begin
        sck_in = ~sck_in;
        if (bp >= 0) mosi_in = mtx[bp];
        bp--;
      end
      repeat (8) @(negedge clk);
    end
    ss_n_in = 1;
    repeat (4) @(negedge clk);
    chk("R4 follower sent word", got, stx);
    chk("R4 follower received word", data_rdata, mtx);
    chk("R10 follower done", stat_done, 1);
    rd_stat(); rd_data();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset ctrl", ctrl_rdata, 0);
    chk("R11 reset flags", {stat_done, stat_fault, irq}, 0);
    chk("R11 no drive when disabled", {sck_oe, mosi_oe, miso_oe}, 0);

    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 4; d++) begin
        m_xfer(2'(d), m[1], m[0], 8'hA5, 8'h3C);
        m_xfer(2'(d), m[1], m[0], 8'h80, 8'h01);
      end

    for (int m = 0; m < 4; m++) begin
      s_xfer(m[1], m[0], 8'hC3, 8'h5A);
      s_xfer(m[1], m[0], 8'h01, 8'hFE);
    end

    // Idle level frozen while enabled.
    wr_ctrl(7'h00);
    wr_ctrl(cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    wr_ctrl(cfg(2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
    chk("R6 idle bit kept while enabled", ctrl_rdata[3], 0);
    chk("R6 sck idle kept while enabled", sck_out, 0);
    wr_ctrl(7'h00);
    wr_ctrl(cfg(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    chk("R6 idle bit taken while disabled", ctrl_rdata[3], 1);
    chk("R6 sck idle taken while disabled", sck_out, 1);

    // Mode fault with interrupts enabled.
    wr_ctrl(7'h00);
    wr_ctrl(cfg(2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
    ss_n_in = 0;
    repeat (5) @(negedge clk);
    chk("R7 fault flag", stat_fault, 1);
    chk("R7 enable and owner cleared", ctrl_rdata[1:0], 0);
    chk("R8 irq on fault with ie", irq, 1);
    chk("R11 outputs released after fault", {sck_oe, mosi_oe, miso_oe}, 0);
    wr_ctrl(cfg(2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    chk("R9 fault held without status read", stat_fault, 1);
    rd_stat();
    wr_ctrl(7'h00);
    chk("R9 fault cleared", stat_fault, 0);
    chk("R8 irq low after clear", irq, 0);
    ss_n_in = 1;
    repeat (4) @(negedge clk);

    // Mode fault with interrupts disabled.
    wr_ctrl(cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    ss_n_in = 0;
    repeat (5) @(negedge clk);
    chk("R7 fault flag without ie", stat_fault, 1);
    chk("R8 no irq without ie", irq, 0);
    ss_n_in = 1;
    rd_stat(); wr_ctrl(7'h00);
    chk("R9 fault cleared again", stat_fault, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule